// File: doc/BRIEF.md
# Write Precompensation and Pulse Shaper

This block sits between a floppy disk controller and the drive-side data path. Each rising edge on the raw write-data line starts one output write pulse of fixed width. In double density, the start of that pulse is moved by a phase delay picked from the controller's EARLY and LATE hints. In single density, every pulse uses the nominal delay. A strobe rises at the accepted edge and stays high until the shaped pulse ends.

Raw read-data edges are stretched to the same fixed width. A clock-recovery enable is produced from the write gate and an active-low VFO-enable input. All timing is counted in cycles of a fast system clock. The pulse width and the phase step are parameters. At the default 100 MHz clock, the 45-cycle pulse lasts 450 ns.

Top module: `wpc_shaper`

## Requirements
- R1: While rst_n is low, wr_pulse_o, rd_pulse_o and strobe_o are low.
- R2: Every shaped write pulse lasts exactly PULSE_W clock cycles.
- R3: In double density (dd_n_i = 0), the hints are decoded as follows. early_i=1 with late_i=0 selects phase 0. Both low selects phase 1. early_i=0 with late_i=1 selects phase 2. Both high selects phase 3. The write pulse begins phase×STEP cycles after the first cycle in which strobe_o is high.
- R4: In single density (dd_n_i = 1), the delay is always STEP cycles, whatever early_i and late_i are.
- R5: The hints are sampled only at the clock edge that accepts a write-data rising edge. Changing them later has no effect on that pulse.
- R6: strobe_o goes high one clock after a write-data rising edge is accepted. It falls on the same clock edge at which the shaped write pulse ends.
- R7: A write-data rising edge that arrives while strobe_o is high is ignored.
- R8: A rising edge on rd_data_i produces an rd_pulse_o high for exactly PULSE_W cycles, starting one clock later.
- R9: A read-data rising edge that arrives while rd_pulse_o is high is ignored.
- R10: recov_en_o is high only when wr_gate_i and vfo_en_n_i are both low. wr_gate_i high forces it low.
- R11: wr_pulse_o is never high while strobe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 1 | Raw write data from the controller |
| early_i | input | 1 | Early precompensation hint |
| late_i | input | 1 | Late precompensation hint |
| dd_n_i | input | 1 | Density flag: 0 = double density, 1 = single density |
| wr_gate_i | input | 1 | Write gate; high while writing |
| vfo_en_n_i | input | 1 | Clock-recovery enable request, active low |
| rd_data_i | input | 1 | Raw read data from the drive |
| wr_pulse_o | output | 1 | Shaped, phase-shifted write pulse |
| rd_pulse_o | output | 1 | Shaped read pulse |
| strobe_o | output | 1 | High from accepted write edge to end of pulse |
| recov_en_o | output | 1 | Clock-recovery enable |

## Verification
The bench measures the start offset and the width of the write pulse for all four hint codes, and again in single density. A swapped phase decode shows up as a pulse that starts at the wrong offset. A design that applies precompensation in single density also starts pulses at the wrong offset. Two further tests target the sampling point of the hints. One moves the hints mid-pulse; a design that decodes live inputs would stretch or shift that pulse. The other sends a second write edge and a second read edge into an active pulse; a retriggering design would yield a longer pulse or a second one. The enable is swept over all four combinations of write gate and VFO enable, which exposes a wrong polarity or a missing override by write gate.

// File: rtl/wpc_shaper.sv
module wpc_shaper #(
  parameter int PULSE_W = 45,
  parameter int STEP    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_data_i,
  input  logic early_i,
  input  logic late_i,
  input  logic dd_n_i,
  input  logic wr_gate_i,
  input  logic vfo_en_n_i,
  input  logic rd_data_i,
  output logic wr_pulse_o,
  output logic rd_pulse_o,
  output logic strobe_o,
  output logic recov_en_o
);
  localparam int SPAN = 3 * STEP + PULSE_W;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int RW   = $clog2(PULSE_W + 1);

  logic          wd_q, rd_q;
  logic          busy, rd_busy;
  logic [CW-1:0] t, dsel;
  logic [RW-1:0] rd_cnt;
  logic [1:0]    phase;
  logic          wr_go, rd_go;

  always_comb begin
    if (dd_n_i) phase = 2'd1;
    else case ({early_i, late_i})
      2'b10:   phase = 2'd0;
      2'b00:   phase = 2'd1;
      2'b01:   phase = 2'd2;
      default: phase = 2'd3;
    endcase
  end

  assign wr_go = wr_data_i & ~wd_q & ~busy;
  assign rd_go = rd_data_i & ~rd_q & ~rd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wd_q <= wr_data_i;
      rd_q <= rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      t    <= '0;
      dsel <= '0;
    end else if (wr_go) begin
      busy <= 1'b1;
      t    <= '0;
      dsel <= CW'(phase) * CW'(STEP);
    end else if (busy) begin
      if (t == dsel + CW'(PULSE_W - 1)) busy <= 1'b0;
      t <= t + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_cnt  <= '0;
    end else if (rd_go) begin
      rd_busy <= 1'b1;
      rd_cnt  <= RW'(PULSE_W - 1);
    end else if (rd_busy) begin
      if (rd_cnt == '0) rd_busy <= 1'b0;
      else rd_cnt <= rd_cnt - 1'b1;
    end
  end

  assign strobe_o   = busy;
  assign wr_pulse_o = busy && (t >= dsel) && (t < dsel + CW'(PULSE_W));
  assign rd_pulse_o = rd_busy;
  assign recov_en_o = ~wr_gate_i & ~vfo_en_n_i;

  logic [RW-1:0] wr_run, rd_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run <= '0;
      rd_run <= '0;
    end else begin
      wr_run <= wr_pulse_o ? wr_run + 1'b1 : '0;
      rd_run <= rd_pulse_o ? rd_run + 1'b1 : '0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !wr_pulse_o && !rd_pulse_o && !strobe_o);
  p_wr_not_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> wr_run < RW'(PULSE_W));
  p_wr_full_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_pulse_o) |-> wr_run == RW'(PULSE_W));
  p_sd_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) && $past(dd_n_i) |-> !wr_pulse_o);
  p_strobe_ends_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> $fell(wr_pulse_o));
  p_rd_not_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_o |-> rd_run < RW'(PULSE_W));
  p_rd_full_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_pulse_o) |-> rd_run == RW'(PULSE_W));
  p_recov_off_writing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate_i |-> !recov_en_o);
  p_pulse_in_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> strobe_o);
endmodule

// File: tb/wpc_shaper_test.sv
module wpc_shaper_test;
  localparam int W = 45;
  localparam int S = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_data = 0, early = 0, late = 0, dd_n = 0, wr_gate = 0, vfo_n = 1, rd_data = 0;
  logic wr_pulse, rd_pulse, strobe, recov_en;
  int total = 0, bad = 0, cycles = 0;

  wpc_shaper #(.PULSE_W(W), .STEP(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data), .early_i(early), .late_i(late),
    .dd_n_i(dd_n), .wr_gate_i(wr_gate), .vfo_en_n_i(vfo_n), .rd_data_i(rd_data),
    .wr_pulse_o(wr_pulse), .rd_pulse_o(rd_pulse), .strobe_o(strobe), .recov_en_o(recov_en));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // raise write data, optionally move hints after i==3 and retrigger at i==6
  task automatic write_run(input bit e, input bit l, input bit d, input int exp_dly,
                           input string req, input bit move_hints, input bit retrig);
    int first = -1, width = 0, rises = 0, sfall = -1, s0;
    bit prev = 0;
    early = e; late = l; dd_n = d;
    @(negedge clk); wr_data = 1;
    for (int i = 0; i < exp_dly + W + 20; i++) begin
      @(negedge clk);
      if (i == 0) s0 = strobe;
      if (wr_pulse) begin width++; if (first < 0) first = i; end
      if (wr_pulse && !prev) rises++;
      if (!strobe && sfall < 0 && i > 0) sfall = i;
      prev = wr_pulse;
      if (i == 1) wr_data = 0;
      if (i == 3 && move_hints) begin early = ~e; late = ~l; dd_n = ~d; end
      if (i == 6 && retrig) wr_data = 1;
      if (i == 8) wr_data = 0;
    end
    chk(s0 == 1, "R6 strobe up", s0, 1);
    chk(first == exp_dly, req, first, exp_dly);
    chk(width == W, "R2 width", width, W);
    chk(sfall == exp_dly + W, "R6 strobe fall", sfall, exp_dly + W);
    if (retrig) chk(rises == 1, "R7 single pulse", rises, 1);
    early = 0; late = 0; dd_n = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!wr_pulse && !rd_pulse && !strobe, "R1 reset", {wr_pulse, rd_pulse, strobe}, 0);
    rst_n = 1;
  endtask

  task automatic t_phases;
    write_run(1, 0, 0, 0,     "R3 early", 0, 0);
    write_run(0, 0, 0, S,     "R3 nominal", 0, 0);
    write_run(0, 1, 0, 2 * S, "R3 late", 0, 0);
    write_run(1, 1, 0, 3 * S, "R3 both", 0, 0);
  endtask

  task automatic t_single;
    write_run(1, 0, 1, S, "R4 sd early", 0, 0);
    write_run(0, 1, 1, S, "R4 sd late", 0, 0);
    write_run(1, 1, 1, S, "R4 sd both", 0, 0);
  endtask

  task automatic t_hold;
    write_run(0, 1, 0, 2 * S, "R5 hints held", 1, 0);
  endtask

  task automatic t_wr_retrig;
    write_run(0, 0, 0, S, "R7 start", 0, 1);
    write_run(1, 0, 0, 0, "R7 next accepted", 0, 0);
  endtask

  task automatic t_read(input bit retrig);
    int first = -1, width = 0;
    @(negedge clk); rd_data = 1;
    for (int i = 0; i < W + 20; i++) begin
      @(negedge clk);
      if (rd_pulse) begin width++; if (first < 0) first = i; end
      if (i == 1) rd_data = 0;
      if (i == 10 && retrig) rd_data = 1;
      if (i == 12) rd_data = 0;
    end
    chk(first == 0, "R8 read start", first, 0);
    chk(width == W, retrig ? "R9 read no retrigger" : "R8 read width", width, W);
  endtask

  task automatic t_recov;
    for (int k = 0; k < 4; k++) begin
      wr_gate = k[1]; vfo_n = k[0];
      #1;
      chk(recov_en == (k == 0), "R10 recovery enable", recov_en, k == 0);
    end
    wr_gate = 0; vfo_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_phases();
    t_single();
    t_hold();
    t_wr_retrig();
    t_read(0);
    t_read(1);
    t_recov();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule